// File: doc/BRIEF.md
# Attention-Line Arbitrated Frame Sender

This block sends one length-prefixed frame at a time over a serial bus that several nodes share. Before a node may talk, it has to win a shared open-drain attention line. The line is wired-AND: every node sees it low as soon as any node pulls it down. A frame request carries a destination byte, a payload length, up to `MAX_PAYLOAD` payload bytes and a check byte. The block copies the request into its own buffer when it accepts it. It then holds the attention line low for a guard time of `GUARD_BITS` serial bit times. After that it hands the bytes, one per valid/ready handshake, to an external UART serializer.

The line stays claimed after the last byte has been handed over. It is released only when the serializer reports that the final stop bit has left the wire. Once released, the line must stay free for a fixed hold time (`RELEASE_NS`, 10 µs by default) before this node may claim it again. While a request waits and the line is low because another node holds it, the block counts busy clock cycles. Each finished frame adds one to a sent counter. The bit time is `CLK_HZ / BAUD` clock cycles. The defaults of 50 MHz and 19200 baud give 2604 cycles per bit.

Top module: `atn_frame_tx`

## Requirements
- R1: While reset is asserted and right after it, `attn_oe`, `tx_valid` and `req_ready` are low, and both counters read zero.
- R2: A request is accepted, with `req_ready` high for that one cycle, only when the block is idle, the release hold has ended, `req_valid` is high and `attn_in` is high. `attn_oe` rises at the clock edge that accepts the request.
- R3: In every idle clock cycle after the release hold in which `req_valid` is high but `attn_in` is low, `busy_count` rises by exactly one. In those cycles the request is not accepted and `attn_oe` stays low.
- R4: `attn_oe` is asserted for exactly `GUARD_BITS * (CLK_HZ / BAUD)` clock cycles before `tx_valid` first goes high.
- R5: The frame goes out as `len + 3` bytes, in this order: the destination byte, the length byte, payload bytes 0 to len-1, and the check byte. Payload byte i is taken from `req_payload[8*i+7:8*i]`. A length above `MAX_PAYLOAD` is treated as `MAX_PAYLOAD`, both in the length byte and in the byte count.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value. Each handshake moves exactly one byte.
- R7: After the last byte is handed over, `tx_valid` is low and `attn_oe` stays high until `tx_done` arrives. A `tx_done` pulse that comes while bytes are still being handed over is ignored.
- R8: `attn_oe` falls at the clock edge that samples `tx_done` in the wait state. `sent_count` rises by one on the following edge.
- R9: After a release, no request is accepted until `attn_oe` has been low for `RELEASE_NS` worth of clock cycles. During that hold, a low `attn_in` does not change `busy_count`.
- R10: Once a request is accepted, changes on the request inputs do not affect the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A frame request is pending |
| req_ready | output | 1 | Request accepted this cycle |
| req_dest | input | 8 | Destination address byte |
| req_len | input | LEN_W | Payload length in bytes |
| req_payload | input | 8*MAX_PAYLOAD | Payload bytes, byte i at bits 8i+7:8i |
| req_crc | input | 8 | Check byte sent last |
| attn_in | input | 1 | Sampled level of the shared attention line |
| attn_oe | output | 1 | Pull the attention line low when high |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_done | input | 1 | One-cycle pulse: last stop bit has left the wire |
| sent_count | output | CNT_W | Frames sent, wraps |
| busy_count | output | CNT_W | Cycles a request was refused on a busy line, wraps |

## Verification
The hardest cases to reach are a request that arrives during the 10 µs release hold and a spurious transmit-complete pulse in the middle of a frame. Reaching the first needs a new request raised right after a release, while another node also pulls the line low for part of that hold. The bench does this: it raises a request two cycles after a release and holds the line low for the first part of the hold. It then measures exactly when acceptance comes and checks that the busy count did not move. For the second, the bench injects a `tx_done` pulse during the byte handshakes of randomly chosen frames. Random ready back-pressure, random line contention before acceptance, and request inputs scrambled after acceptance cover the other paths.

// File: rtl/atx_pkg.sv
package atx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GUARD,
        ST_WRITE,
        ST_WAIT_EMPTY,
        ST_SENT
    } atx_state_e;
endpackage

// File: rtl/atx_frame_buf.sv
module atx_frame_buf #(
    parameter int MAX_PAYLOAD = 16,
    parameter int LEN_W       = 5,
    parameter int IDX_W       = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [7:0]               dest_i,
    input  logic [LEN_W-1:0]         len_i,
    input  logic [8*MAX_PAYLOAD-1:0] pay_i,
    input  logic [7:0]               crc_i,
    input  logic [IDX_W-1:0]         idx_i,
    output logic [7:0]               byte_o,
    output logic                     last_o
);
    logic [7:0]       dest_q;
    logic [7:0]       crc_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_clip;
    logic [7:0]       pay_q [MAX_PAYLOAD];
    logic [IDX_W-1:0] pidx;
    logic [IDX_W-1:0] last_idx;
    logic [7:0]       pay_byte;

    // over-long requests are cut to the buffer size
    assign len_clip = (len_i > LEN_W'(MAX_PAYLOAD)) ? LEN_W'(MAX_PAYLOAD) : len_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_q <= '0;
            crc_q  <= '0;
            len_q  <= '0;
        end else if (load_i) begin
            dest_q <= dest_i;
            crc_q  <= crc_i;
            len_q  <= len_clip;
        end
    end

    for (genvar g = 0; g < MAX_PAYLOAD; g++) begin : g_pay
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pay_q[g] <= '0;
            end else if (load_i) begin
                pay_q[g] <= pay_i[8*g +: 8];
            end
        end
    end

    assign pidx     = idx_i - IDX_W'(2);
    assign last_idx = IDX_W'(len_q) + IDX_W'(2);

    always_comb begin
        pay_byte = '0;
        for (int k = 0; k < MAX_PAYLOAD; k++) begin
            if (pidx == IDX_W'(k)) begin
                pay_byte = pay_q[k];
            end
        end
    end

    always_comb begin
        if (idx_i == '0) begin
            byte_o = dest_q;
        end else if (idx_i == IDX_W'(1)) begin
            byte_o = 8'(len_q);
        end else if (idx_i == last_idx) begin
            byte_o = crc_q;
        end else begin
            byte_o = pay_byte;
        end
    end

    assign last_o = (idx_i == last_idx);
endmodule

// File: rtl/atx_timer.sv
module atx_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/atx_count.sv
module atx_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/atn_frame_tx.sv
module atn_frame_tx
    import atx_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BAUD        = 19200,
    parameter int GUARD_BITS  = 2,
    parameter int RELEASE_NS  = 10_000,
    parameter int MAX_PAYLOAD = 16,
    parameter int CNT_W       = 16,
    localparam int LEN_W      = $clog2(MAX_PAYLOAD + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [7:0]               req_dest,
    input  logic [LEN_W-1:0]         req_len,
    input  logic [8*MAX_PAYLOAD-1:0] req_payload,
    input  logic [7:0]               req_crc,
    input  logic                     attn_in,
    output logic                     attn_oe,
    output logic [7:0]               tx_data,
    output logic                     tx_valid,
    input  logic                     tx_ready,
    input  logic                     tx_done,
    output logic [CNT_W-1:0]         sent_count,
    output logic [CNT_W-1:0]         busy_count
);
    localparam int BIT_CYC     = CLK_HZ / BAUD;
    localparam int GUARD_CYC   = GUARD_BITS * BIT_CYC;
    localparam int RELEASE_CYC = (CLK_HZ / 1000) * RELEASE_NS / 1_000_000;
    localparam int TMAX        = (GUARD_CYC > RELEASE_CYC) ? GUARD_CYC : RELEASE_CYC;
    localparam int TIM_W       = $clog2(TMAX + 1);
    localparam int IDX_W       = $clog2(MAX_PAYLOAD + 3);

    typedef struct packed {
        atx_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             oe;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             t_zero, t_load;
    logic [TIM_W-1:0] t_val;
    logic             buf_load, buf_last;
    logic [7:0]       buf_byte;
    logic             sent_inc, busy_inc;
    logic             line_turn;

    // idle with the release hold over: the node may try for the line
    assign line_turn = (ctl_q.st == ST_IDLE) && t_zero && req_valid;

    always_comb begin
        ctl_d     = ctl_q;
        t_load    = 1'b0;
        t_val     = '0;
        buf_load  = 1'b0;
        sent_inc  = 1'b0;
        busy_inc  = 1'b0;
        req_ready = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (line_turn && attn_in) begin
                    req_ready = 1'b1;
                    buf_load  = 1'b1;
                    t_load    = 1'b1;
                    t_val     = TIM_W'(GUARD_CYC - 1);
                    ctl_d.st  = ST_GUARD;
                    ctl_d.oe  = 1'b1;
                    ctl_d.idx = '0;
                end else if (line_turn) begin
                    busy_inc = 1'b1;
                end
            end
            ST_GUARD: begin
                if (t_zero) ctl_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                if (tx_ready) begin
                    if (buf_last) ctl_d.st = ST_WAIT_EMPTY;
                    else          ctl_d.idx = ctl_q.idx + IDX_W'(1);
                end
            end
            ST_WAIT_EMPTY: begin
                if (tx_done) begin
                    ctl_d.st = ST_SENT;
                    ctl_d.oe = 1'b0;
                    t_load   = 1'b1;
                    t_val    = TIM_W'(RELEASE_CYC - 1);
                end
            end
            ST_SENT: begin
                sent_inc = 1'b1;
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
                ctl_d.oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, idx: '0, oe: 1'b0};
        else        ctl_q <= ctl_d;
    end

    atx_frame_buf #(
        .MAX_PAYLOAD(MAX_PAYLOAD), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) i_buf (
        .clk(clk), .rst_n(rst_n), .load_i(buf_load),
        .dest_i(req_dest), .len_i(req_len), .pay_i(req_payload), .crc_i(req_crc),
        .idx_i(ctl_q.idx), .byte_o(buf_byte), .last_o(buf_last)
    );

    atx_timer #(.W(TIM_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load_i(t_load), .val_i(t_val), .zero_o(t_zero)
    );

    atx_count #(.W(CNT_W)) i_sent_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(sent_inc), .count_o(sent_count)
    );

    atx_count #(.W(CNT_W)) i_busy_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(busy_inc), .count_o(busy_count)
    );

    assign attn_oe  = ctl_q.oe;
    assign tx_valid = (ctl_q.st == ST_WRITE);
    assign tx_data  = buf_byte;
endmodule

// File: rtl/atx_checker.sv
module atx_checker #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int RELEASE_NS = 10_000,
    parameter int CNT_W      = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             attn_in,
    input logic             attn_oe,
    input logic [7:0]       tx_data,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             tx_done,
    input logic [CNT_W-1:0] busy_count
);
    localparam int REL_CYC = (CLK_HZ / 1000) * RELEASE_NS / 1_000_000;

    // cycles the line has been left free since the last release
    logic [31:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     gap_q <= 32'(REL_CYC);
        else if (attn_oe)               gap_q <= '0;
        else if (gap_q < 32'(REL_CYC))  gap_q <= gap_q + 32'd1;
    end

    a_r2_claim_on_free_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(attn_oe) |-> $past(attn_in));

    a_r2_accept_while_free: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (attn_in && !attn_oe));

    a_r3_busy_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_count != $past(busy_count)) |-> (busy_count - $past(busy_count) == CNT_W'(1)));

    a_r6_hold_offered_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    a_r7_bytes_under_claim: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> attn_oe);

    a_r8_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(attn_oe) |-> $past(tx_done));

    a_r9_hold_respected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(attn_oe) |-> (gap_q >= 32'(REL_CYC)));
endmodule

bind atn_frame_tx atx_checker #(
    .CLK_HZ(CLK_HZ), .RELEASE_NS(RELEASE_NS), .CNT_W(CNT_W)
) i_atx_checker (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .attn_in(attn_in),
    .attn_oe(attn_oe), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_done(tx_done), .busy_count(busy_count)
);

// File: tb/test_atn_frame_tx.sv
module test_atn_frame_tx;
    localparam int MAXP  = 16;
    localparam int LW    = $clog2(MAXP + 1);
    localparam int GCYC  = 40;   // 2 bits at 50 MHz / 2.5 Mbaud
    localparam int RCYC  = 500;  // 10 us at 50 MHz

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [7:0]      req_dest = '0;
    logic [LW-1:0]   req_len = '0;
    logic [8*MAXP-1:0] req_payload = '0;
    logic [7:0]      req_crc = '0;
    logic            ext_low = 1'b0;
    logic            attn_in;
    logic            attn_oe;
    logic [7:0]      tx_data;
    logic            tx_valid;
    logic            tx_ready = 1'b0;
    logic            tx_done = 1'b0;
    logic [15:0]     sent_count;
    logic [15:0]     busy_count;

    assign attn_in = ~(attn_oe | ext_low);

    always #10 clk = ~clk;

    atn_frame_tx #(.CLK_HZ(50_000_000), .BAUD(2_500_000), .MAX_PAYLOAD(MAXP)) i_atn_frame_tx (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dest(req_dest), .req_len(req_len), .req_payload(req_payload), .req_crc(req_crc),
        .attn_in(attn_in), .attn_oe(attn_oe), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_done(tx_done), .sent_count(sent_count), .busy_count(busy_count)
    );

    int checks = 0;
    int errors = 0;
    int exp_sent = 0;
    int exp_busy = 0;
    logic [7:0]      f_dest, f_crc;
    logic [LW-1:0]   f_len;
    logic [8*MAXP-1:0] f_pay;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clip_len();
        return (int'(f_len) > MAXP) ? MAXP : int'(f_len);
    endfunction

    function automatic logic [7:0] exp_byte(input int i);
        int l = clip_len();
        if (i == 0)     return f_dest;
        if (i == 1)     return 8'(l);
        if (i == l + 2) return f_crc;
        return f_pay[8*(i-2) +: 8];
    endfunction

    task automatic pick_frame(input int len);
        f_dest = 8'($urandom);
        f_crc  = 8'($urandom);
        f_len  = LW'(len);
        for (int k = 0; k < MAXP; k++) f_pay[8*k +: 8] = 8'($urandom);
    endtask

    task automatic drive_req();
        req_dest = f_dest; req_len = f_len; req_payload = f_pay; req_crc = f_crc;
        req_valid = 1'b1;
    endtask

    // line pulled low by another node for `busy` cycles, then accepted
    task automatic request(input int busy);
        @(negedge clk);
        drive_req();
        ext_low = (busy > 0);
        for (int k = 0; k < busy; k++) begin
            #1;
            if (k == 0) chk(!req_ready && !attn_oe, "R3 refused while line low", int'(req_ready), 0);
            @(negedge clk);
        end
        ext_low = 1'b0;
        exp_busy += busy;
        #1;
        chk(busy_count == 16'(exp_busy), "R3 busy_count", int'(busy_count), exp_busy);
        chk(req_ready == 1'b1, "R2 accept on free line", int'(req_ready), 1);
    endtask

    task automatic body(input bit early, input bit ready_all, input bit keep_close);
        int g = 0;
        int n = clip_len() + 3;
        int got = 0;
        int bad = 0;
        int unstable = 0;
        bit pend = 1'b0;
        bit early_done = 1'b0;
        logic [7:0] pdat = '0;
        logic [7:0] rx [MAXP+3];
        @(negedge clk);
        req_valid = 1'b0;
        req_dest = 8'($urandom); req_len = LW'($urandom); req_crc = 8'($urandom);
        req_payload = {4{32'($urandom)}};   // R10: inputs scrambled after acceptance
        chk(attn_oe == 1'b1, "R2 claim after accept", int'(attn_oe), 1);
        while (!tx_valid) begin
            if (attn_oe) g++;
            @(negedge clk);
        end
        chk(g == GCYC, "R4 guard length", g, GCYC);
        while (got < n) begin
            tx_done = 1'b0;
            if (tx_valid) begin
                bit r = ready_all | 1'($urandom);
                if (pend && tx_data != pdat) unstable++;
                tx_ready = r;
                if (r) begin
                    rx[got] = tx_data; got++; pend = 1'b0;
                end else begin
                    pend = 1'b1; pdat = tx_data;
                end
                if (early && got == 2 && !early_done) begin
                    tx_done = 1'b1; early_done = 1'b1;
                end
            end else begin
                tx_ready = 1'b0;
            end
            @(negedge clk);
        end
        tx_ready = 1'b0;
        tx_done = 1'b0;
        chk(unstable == 0, "R6 data held under back-pressure", unstable, 0);
        for (int i = 0; i < n; i++) if (rx[i] != exp_byte(i)) bad++;
        chk(bad == 0, "R5 R10 frame bytes", bad, 0);
        chk(!tx_valid && attn_oe, "R7 line held after last byte", int'(attn_oe), 1);
        for (int w = 0; w < 2 + int'($urandom % 5); w++) @(negedge clk);
        chk(attn_oe == 1'b1, "R7 line held until done", int'(attn_oe), 1);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        chk(attn_oe == 1'b0, "R8 release on done", int'(attn_oe), 0);
        @(negedge clk);
        exp_sent++;
        chk(sent_count == 16'(exp_sent), "R8 sent_count", int'(sent_count), exp_sent);
        if (!keep_close) repeat (RCYC + 2) @(negedge clk);
    endtask

    // R9: a new request raised right after a release, line low early in the hold
    task automatic hold_probe();
        int n = 2;
        int b0 = int'(busy_count);
        pick_frame(3);
        drive_req();
        ext_low = 1'b1;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
            n++;
            if (n == 100) ext_low = 1'b0;
        end
        chk(n == RCYC, "R9 hold before next claim", n, RCYC);
        chk(int'(busy_count) == b0, "R9 no busy count during hold", int'(busy_count), b0);
    endtask

    initial begin : watchdog
        repeat (150_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!attn_oe && !tx_valid && !req_ready, "R1 outputs in reset", int'(attn_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sent_count == 0 && busy_count == 0, "R1 counters after reset", int'(sent_count), 0);
        // directed: empty payload, no back-pressure
        pick_frame(0);  request(0); body(1'b0, 1'b1, 1'b0);
        // directed: full payload with contention and an early done pulse
        pick_frame(MAXP); request(4); body(1'b1, 1'b0, 1'b0);
        // directed: over-long length is clipped
        pick_frame(25); request(0); body(1'b0, 1'b0, 1'b1);
        hold_probe();   body(1'b0, 1'b1, 1'b0);
        for (int f = 0; f < 10; f++) begin
            pick_frame(int'($urandom % (MAXP + 1)));
            request(int'($urandom % 4));
            body(1'($urandom), 1'b0, 1'b0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule